// File: doc/BRIEF.md
# Two-Wire Register Slave

This block is a slave on a two-wire serial bus that runs on a fast internal clock. It does not use the bus clock as a clock. Both bus lines pass through two-flop synchronizers, and edge detection on the synchronized copies finds START, STOP and the SCL edges. The slave answers to a 7-bit address. The top six bits of that address are fixed, and the lowest bit comes from a strap pin. The first byte of a write is a command byte that selects a register. The data byte after it goes out on a shared data bus together with a one-cycle write strobe for the selected register. The registers themselves live outside this block.

A read returns the register that the last command byte selected. That command byte is usually written just before the read, followed by a repeated START. The temperature command returns two bytes, high byte first, and the master may stop after the first byte. The pointer never advances, so each new access has to send its command byte again. The block drives SDA with a single pull-low enable. An external pull-up supplies the high level.

Top module: `twi_reg_slave`

## Requirements
- R1: START is SDA falling while SCL is high and STOP is SDA rising while SCL is high. Bits are sampled on rising SCL, MSB first. The slave changes its SDA drive only while SCL is low.
- R2: The slave answers to address bits `100010` followed by the value of `addr_pin`. The eighth bit is R/W, with 0 meaning write and 1 meaning read. A matching address is acknowledged by pulling SDA low through the ninth clock.
- R3: The slave does not acknowledge an address that does not match. It then leaves the bus alone and produces no strobe until the next START or STOP.
- R4: The slave acknowledges the command byte and the data byte of a write. Command 5Dh pulses `wr_div`, 60h pulses `wr_ctrl` and 66h pulses `wr_tune`, each for one cycle, with the data byte on `wr_data`.
- R5: The pointer never auto-increments. Only the first data byte after a command is written. Later bytes are acknowledged but raise no strobe, and every read byte after the first returns FFh, except for the second temperature byte.
- R6: A command byte outside 5Dh/60h/66h/64h is acknowledged. Data written to it raises no strobe, and a read of it returns FFh.
- R7: After command 64h, a read returns `temp_rd[15:8]` and then `temp_rd[7:0]`. After 5Dh, 60h or 66h, the first read byte is `div_rd`, `ctrl_rd` or `tune_rd`.
- R8: When the master answers a read byte with NACK, the slave releases SDA and leaves it high until the next START or STOP.
- R9: A repeated START begins a new address phase. It keeps the command byte, so a write of the command followed by a repeated START and a read returns that register.
- R10: During reset the slave does not drive SDA and no write strobe is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_pin | input | 1 | Strap that sets the lowest address bit |
| div_rd | input | 8 | Current divider-select register value |
| ctrl_rd | input | 8 | Current control register value |
| tune_rd | input | 8 | Current tuning register value |
| temp_rd | input | 16 | Latest temperature result, high byte in [15:8] |
| sda_oe | output | 1 | 1 pulls SDA low |
| wr_data | output | 8 | Data byte that goes with a write strobe |
| wr_div | output | 1 | Write strobe for divider select |
| wr_ctrl | output | 1 | Write strobe for control |
| wr_tune | output | 1 | Write strobe for tuning offset |

## Verification
A change on `scl_i` or `sda_i` reaches the synchronized copy after two clocks. The edge is acted on at the third rising clock edge, so `sda_oe` and the write strobes change three cycles after the bus edge that causes them. The bench models the bus master with a quarter bit of ten clocks. It sets the master's data level right after an SCL fall and samples the wired-AND line in the middle of the SCL high phase, long after the three-cycle latency has passed. The bench counts strobes on falling clock edges. It compares the strobe count and data only after the STOP, so the one-cycle pulse is never missed or counted twice.

// File: rtl/twi_reg_slave.sv
module twi_reg_slave #(
  parameter logic [5:0] ADDR_HI  = 6'b100010,
  parameter logic [7:0] CMD_DIV  = 8'h5D,
  parameter logic [7:0] CMD_CTRL = 8'h60,
  parameter logic [7:0] CMD_TEMP = 8'h64,
  parameter logic [7:0] CMD_TUNE = 8'h66
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  input  logic        addr_pin,
  input  logic [7:0]  div_rd,
  input  logic [7:0]  ctrl_rd,
  input  logic [7:0]  tune_rd,
  input  logic [15:0] temp_rd,
  output logic        sda_oe,
  output logic [7:0]  wr_data,
  output logic        wr_div,
  output logic        wr_ctrl,
  output logic        wr_tune
);
  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_CMD, S_WDAT, S_RDAT, S_IGN} st_t;

  logic [1:0] scl_m, sda_m;
  logic       scl_d, sda_d;
  logic       scl_s, sda_s;
  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, txsr, cmd, rd_byte;
  logic [1:0] rd_idx;
  logic       ack, tx_en, rw, mnack, wr_done;

  assign scl_s = scl_m[1];
  assign sda_s = sda_m[1];

  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire active   = (st != S_IDLE) && (st != S_IGN);

  assign sda_oe = ack | (tx_en & ~txsr[7]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_m <= 2'b11; sda_m <= 2'b11; scl_d <= 1'b1; sda_d <= 1'b1;
    end else begin
      scl_m <= {scl_m[0], scl_i};
      sda_m <= {sda_m[0], sda_i};
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  always_comb begin
    rd_byte = 8'hFF;
    case (cmd)
      CMD_DIV:  if (rd_idx == 2'd0) rd_byte = div_rd;
      CMD_CTRL: if (rd_idx == 2'd0) rd_byte = ctrl_rd;
      CMD_TUNE: if (rd_idx == 2'd0) rd_byte = tune_rd;
      CMD_TEMP: if (rd_idx == 2'd0) rd_byte = temp_rd[15:8];
                else if (rd_idx == 2'd1) rd_byte = temp_rd[7:0];
      default:  rd_byte = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; sr <= '0; txsr <= 8'hFF; cmd <= 8'hFF;
      rd_idx <= '0; ack <= 1'b0; tx_en <= 1'b0; rw <= 1'b0; mnack <= 1'b1;
      wr_done <= 1'b0; wr_data <= '0; wr_div <= 1'b0; wr_ctrl <= 1'b0; wr_tune <= 1'b0;
    end else begin
      wr_div <= 1'b0; wr_ctrl <= 1'b0; wr_tune <= 1'b0;
      if (start) begin
        st <= S_ADDR; cnt <= '0; ack <= 1'b0; tx_en <= 1'b0;
        rd_idx <= '0; wr_done <= 1'b0;
      end else if (stop) begin
        st <= S_IDLE; cnt <= '0; ack <= 1'b0; tx_en <= 1'b0;
      end else if (active && scl_rise) begin
        if (cnt < 4'd8) begin
          sr  <= {sr[6:0], sda_s};
          cnt <= cnt + 4'd1;
        end else if (cnt == 4'd8) begin
          mnack <= sda_s;
          cnt   <= 4'd9;
        end
      end else if (active && scl_fall) begin
        if (cnt == 4'd8) begin
          case (st)
            S_ADDR: if (sr[7:1] == {ADDR_HI, addr_pin}) begin
                      ack <= 1'b1; rw <= sr[0];
                    end else st <= S_IGN;
            S_CMD:  begin ack <= 1'b1; cmd <= sr; end
            S_WDAT: begin
                      ack <= 1'b1;
                      if (!wr_done) begin
                        wr_done <= 1'b1;
                        wr_data <= sr;
                        wr_div  <= (cmd == CMD_DIV);
                        wr_ctrl <= (cmd == CMD_CTRL);
                        wr_tune <= (cmd == CMD_TUNE);
                      end
                    end
            S_RDAT: begin
                      tx_en <= 1'b0;
                      if (rd_idx != 2'd2) rd_idx <= rd_idx + 2'd1;
                    end
            default: ;
          endcase
        end else if (cnt == 4'd9) begin
          ack <= 1'b0;
          cnt <= '0;
          case (st)
            S_ADDR: if (rw) begin
                      st <= S_RDAT; tx_en <= 1'b1; txsr <= rd_byte;
                    end else st <= S_CMD;
            S_CMD:  st <= S_WDAT;
            S_RDAT: if (mnack) st <= S_IGN;
                    else begin tx_en <= 1'b1; txsr <= rd_byte; end
            default: ;
          endcase
        end else if (tx_en && cnt != 4'd0) begin
          txsr <= {txsr[6:0], 1'b1};
        end
      end
    end
endmodule

module twi_reg_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic sda_oe,
  input logic wr_div,
  input logic wr_ctrl,
  input logic wr_tune,
  input logic ign
);
  assert_sda_hold_scl_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe));

  assert_ignore_no_drive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ign |-> !sda_oe);

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_div, wr_ctrl, wr_tune}));

  assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_div || wr_ctrl || wr_tune) |=> !(wr_div || wr_ctrl || wr_tune));

  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R10: assert (!wr_div && !wr_ctrl && !wr_tune);
endmodule

bind twi_reg_slave twi_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .wr_div(wr_div), .wr_ctrl(wr_ctrl), .wr_tune(wr_tune), .ign(st == S_IGN)
);

// File: tb/twi_reg_slave_bench.sv
module twi_reg_slave_bench;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h88, AR = 8'h89;
  // cmd[17:10] data[9:2] kind[1:0] (0 none, 1 div, 2 ctrl, 3 tune)
  localparam logic [17:0] VEC [5] = '{
    {8'h5D, 8'hA5, 2'd1},
    {8'h60, 8'h0B, 2'd2},
    {8'h66, 8'hE8, 2'd3},
    {8'h42, 8'h77, 2'd0},
    {8'h66, 8'h7F, 2'd3}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, addr_pin = 1'b0;
  logic sda_oe, wr_div, wr_ctrl, wr_tune;
  logic [7:0] wr_data;
  wire  sda_bus = sda_m & ~sda_oe;

  int n_chk = 0, n_bad = 0, n_str = 0;
  logic [1:0] last_kind = 2'd0;
  logic [7:0] last_data = 8'h00;
  logic done = 1'b0;

  always #2 clk = ~clk;

  twi_reg_slave u_twi_reg_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_pin(addr_pin),
    .div_rd(8'h3C), .ctrl_rd(8'h05), .tune_rd(8'h9C), .temp_rd(16'h4B80),
    .sda_oe(sda_oe), .wr_data(wr_data), .wr_div(wr_div), .wr_ctrl(wr_ctrl), .wr_tune(wr_tune)
  );

  always @(negedge clk) if (rst_n) begin
    if (wr_div)  begin n_str++; last_kind = 2'd1; last_data = wr_data; end
    if (wr_ctrl) begin n_str++; last_kind = 2'd2; last_data = wr_data; end
    if (wr_tune) begin n_str++; last_kind = 2'd3; last_data = wr_data; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic bit_io(input logic b, output logic got);
    sda_m = b; wq(); scl = 1'b1; wq(); got = sda_bus; wq(); scl = 1'b0; wq();
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack_n);
    logic x;
    for (int i = 7; i >= 0; i--) bit_io(b[i], x);
    bit_io(1'b1, ack_n);
  endtask

  task automatic rbyte(input logic nack, output logic [7:0] b);
    logic x;
    for (int i = 7; i >= 0; i--) bit_io(1'b1, b[i]);
    bit_io(nack, x);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic a;
    logic [7:0] d;
    int s0;
    repeat (5) @(negedge clk);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset strobes", {wr_div, wr_ctrl, wr_tune}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      s0 = n_str;
      bus_start();
      wbyte(AW, a);            chk("R2 address ack", a, 0);
      wbyte(VEC[i][17:10], a); chk("R4 R6 command ack", a, 0);
      wbyte(VEC[i][9:2], a);   chk("R4 data ack", a, 0);
      bus_stop();
      if (VEC[i][1:0] == 2'd0) chk("R6 write discarded", n_str - s0, 0);
      else begin
        chk("R4 strobe count", n_str - s0, 1);
        chk("R4 strobe target", last_kind, VEC[i][1:0]);
        chk("R4 strobe data", last_data, VEC[i][9:2]);
      end
    end

    s0 = n_str;
    bus_start(); wbyte(AW, a); wbyte(8'h60, a); wbyte(8'h11, a);
    wbyte(8'h22, a); chk("R5 extra byte ack", a, 0);
    bus_stop();
    chk("R5 single strobe", n_str - s0, 1);
    chk("R5 first byte kept", last_data, 8'h11);

    bus_start(); wbyte(AW, a); wbyte(8'h60, a);
    bus_start(); wbyte(AR, a); chk("R9 read address ack", a, 0);
    rbyte(1'b0, d); chk("R9 R7 control read", d, 8'h05);
    rbyte(1'b1, d); chk("R5 no auto increment", d, 8'hFF);
    bus_stop();

    bus_start(); wbyte(AW, a); wbyte(8'h64, a);
    bus_start(); wbyte(AR, a);
    rbyte(1'b0, d); chk("R7 R1 temp high byte", d, 8'h4B);
    rbyte(1'b1, d); chk("R7 R1 temp low byte", d, 8'h80);
    bus_stop();

    bus_start(); wbyte(AW, a); wbyte(8'h64, a);
    bus_start(); wbyte(AR, a);
    rbyte(1'b1, d); chk("R7 temp single byte", d, 8'h4B);
    chk("R8 released after nack", sda_oe, 0);
    rbyte(1'b1, d); chk("R8 line stays high", d, 8'hFF);
    bus_stop();

    bus_start(); wbyte(AW, a); wbyte(8'h5D, a);
    bus_start(); wbyte(AR, a); rbyte(1'b1, d); bus_stop();
    chk("R7 divider read", d, 8'h3C);

    bus_start(); wbyte(AW, a); wbyte(8'h42, a);
    bus_start(); wbyte(AR, a); rbyte(1'b1, d); bus_stop();
    chk("R6 unknown read", d, 8'hFF);

    s0 = n_str;
    bus_start(); wbyte(8'h8A, a); chk("R3 mismatch nack", a, 1);
    wbyte(8'h66, a); chk("R3 ignored byte", a, 1);
    wbyte(8'h01, a); bus_stop();
    chk("R3 no strobe", n_str - s0, 0);

    addr_pin = 1'b1;
    repeat (5) @(negedge clk);
    bus_start(); wbyte(AW, a); chk("R2 strap mismatch nack", a, 1); bus_stop();
    bus_start(); wbyte(8'h8A, a); chk("R2 strap address ack", a, 0);
    wbyte(8'h66, a); wbyte(8'h3A, a); bus_stop();
    chk("R2 strap write", {last_kind, last_data}, {2'd3, 8'h3A});

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule